// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one accepted read or write command into the column address sequence and the byte-lane timing of a synchronous DRAM burst. On each accepted command it latches the start column, the bank and the relevant fields of a programmed mode word. It then steps through the beats of the burst, one beat per clock. Two wrap orders are supported: sequential and interleaved. Burst lengths are 1, 2, 4 and 8 beats, plus an open-ended full-page burst that runs until it is stopped.

Write beats drive a per-lane write enable. A high byte mask blocks a lane in the same cycle. Read beats feed a short pipeline. That pipeline raises a read-data-valid flag aligned to the programmed CAS latency and drives a per-lane output enable. The output enable is cleared for any lane whose mask was high two edges earlier. The memory array, row activation and refresh sit outside this block.

Top module: `sdram_burst_seq`

## Requirements
- R1: While rst_ni is low, beat_vld_o, beat_wr_o, wr_en_o, rd_vld_o, rd_oe_o and bank_o are all zero.
- R2: A command sampled with cmd_vld_i high puts beat 0 on the outputs in the following cycle: beat_vld_o is 1 and col_o equals the sampled col_i. Commands on consecutive edges each take effect on the next cycle.
- R3: Mode bits [2:0] select the burst length (000 = 1, 001 = 2, 100/101/110 = 1, 010 = 4, 011 = 8, 111 = full page). With mode bit [3] = 0 (sequential), beat n of a burst of length L addresses the L-aligned block holding the start column at offset (start mod L + n) mod L.
- R4: With mode bit [3] = 1 (interleaved), beat n of a burst of length L uses offset (start mod L) XOR n inside the same aligned block. A full-page burst always uses the sequential order.
- R5: A burst of length L shows exactly L beats on consecutive cycles and then drops beat_vld_o.
- R6: A full-page burst steps the column up by one each cycle. It wraps from 511 to 0 and continues past its start column for as long as no stop or new command arrives.
- R7: stop_i sampled high with cmd_vld_i low ends the burst: beat_vld_o is 0 in the next cycle. If stop_i and cmd_vld_i are both high, the command wins.
- R8: A new command sampled during a burst truncates the old burst. Its own beat 0 follows in the next cycle.
- R9: With mode bit [9] = 1, every write command yields a single beat, whatever the burst length. Reads still burst at the programmed length.
- R10: During a write beat, wr_en_o[i] = NOT dqm_i[i] in the same cycle, with bit 1 as the upper lane and bit 0 as the lower lane. Outside write beats wr_en_o is 0.
- R11: Mode bits [6:4] = 011 select CAS latency 3; any other value selects 2. For a read command sampled at edge k, beat n's data is flagged by rd_vld_o in the cycle that ends at edge k+n+CL.
- R12: In a cycle with rd_vld_o high, rd_oe_o[i] is 0 exactly when dqm_i[i] was sampled high two edges before the end of that cycle. rd_oe_o is 0 whenever rd_vld_o is 0.
- R13: bank_o holds the bank sampled with the most recent command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_vld_i | input | 1 | Read or write command strobe |
| cmd_wr_i | input | 1 | 1 = write, 0 = read |
| col_i | input | 9 | Start column |
| bank_i | input | 2 | Bank of the command |
| stop_i | input | 1 | Burst stop strobe |
| mode_i | input | 10 | Mode word: length, order, CAS latency, single-beat writes |
| dqm_i | input | 2 | Byte masks, bit 1 upper, bit 0 lower |
| col_o | output | 9 | Column of the current beat |
| bank_o | output | 2 | Bank of the current burst |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| beat_wr_o | output | 1 | The current beat is a write |
| wr_en_o | output | 2 | Per-lane write enable |
| rd_vld_o | output | 1 | Read data valid, CAS-latency aligned |
| rd_oe_o | output | 2 | Per-lane read output enable |

## Verification
Sequential bursts start from a column in the middle of a block, so that the wrap inside the block is visible. Interleaved bursts use the same kind of start columns, which separates XOR ordering from addition. Full-page runs start just below 512 and last longer than 512 beats, which exposes both the wrap to zero and the lack of a length limit. The tests also interrupt bursts with stops and with new commands, issue back-to-back commands, and use single-beat write mode on both directions. Masks change every cycle during read bursts at both CAS latencies, so a mask offset by one cycle, or a read mask treated like a write mask, shows up at once.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam int MODE_W   = 10;
  localparam int BL_LSB   = 0;
  localparam int TYPE_BIT = 3;
  localparam int CL_LSB   = 4;
  localparam int WBS_BIT  = 9;

  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;

  localparam logic [2:0] CL_THREE = 3'b011;
endpackage

// File: rtl/seq_col_gen.sv
module seq_col_gen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low;

  always_comb begin
    if (ilv_i) low = start_i ^ cnt_i;
    else       low = start_i + cnt_i;
    col_o = (start_i & ~mask_i) | (low & mask_i);
  end
endmodule

// File: rtl/seq_burst_ctrl.sv
module seq_burst_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  logic              cmd_wr_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              stop_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              act_o,
  output logic              wr_o,
  output logic [COL_W-1:0]  start_o,
  output logic [COL_W-1:0]  cnt_o,
  output logic [COL_W-1:0]  mask_o,
  output logic              ilv_o,
  output logic              cl3_o,
  output logic [BANK_W-1:0] bank_o
);
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] ONE      = COL_W'(1);

  logic             full_q, full_d;
  logic [COL_W-1:0] mask_d;
  bl_code_e         bl;

  // length decode; single-beat writes override
  always_comb begin
    bl     = bl_code_e'(mode_i[BL_LSB +: 3]);
    full_d = 1'b0;
    unique case (bl)
      BL_2:    mask_d = COL_W'(1);
      BL_4:    mask_d = COL_W'(3);
      BL_8:    mask_d = COL_W'(7);
      BL_PAGE: begin mask_d = ALL_ONES; full_d = 1'b1; end
      default: mask_d = '0;
    endcase
    if (cmd_wr_i && mode_i[WBS_BIT]) begin
      mask_d = '0;
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o   <= 1'b0;
      wr_o    <= 1'b0;
      start_o <= '0;
      cnt_o   <= '0;
      mask_o  <= '0;
      full_q  <= 1'b0;
      ilv_o   <= 1'b0;
      cl3_o   <= 1'b0;
      bank_o  <= '0;
    end else if (cmd_vld_i) begin
      act_o   <= 1'b1;
      wr_o    <= cmd_wr_i;
      start_o <= col_i;
      cnt_o   <= '0;
      mask_o  <= mask_d;
      full_q  <= full_d;
      ilv_o   <= mode_i[TYPE_BIT] & ~full_d;
      cl3_o   <= (mode_i[CL_LSB +: 3] == CL_THREE);
      bank_o  <= bank_i;
    end else if (stop_i) begin
      act_o <= 1'b0;
    end else if (act_o) begin
      if (!full_q && cnt_o == mask_o) act_o <= 1'b0;
      else                            cnt_o <= cnt_o + ONE;
    end
  end
endmodule

// File: rtl/seq_read_pipe.sv
module seq_read_pipe #(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_beat_i,
  input  logic             cl3_i,
  input  logic [LANES-1:0] dqm_i,
  output logic             rd_vld_o,
  output logic [LANES-1:0] rd_oe_o
);
  logic             vld1_q, vld2_q, cl1_q, cl2_q;
  logic [LANES-1:0] msk1_q, msk2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld1_q <= 1'b0;
      vld2_q <= 1'b0;
      cl1_q  <= 1'b0;
      cl2_q  <= 1'b0;
      msk1_q <= '0;
      msk2_q <= '0;
    end else begin
      vld1_q <= rd_beat_i;
      cl1_q  <= cl3_i;
      vld2_q <= vld1_q & cl1_q;
      cl2_q  <= cl1_q;
      msk1_q <= dqm_i;
      msk2_q <= msk1_q;
    end
  end

  // latency 2 taps stage 1, latency 3 taps stage 2
  assign rd_vld_o = (vld1_q & ~cl1_q) | (vld2_q & cl2_q);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_oe_o[g] = rd_vld_o & ~msk2_q[g];
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  logic              cmd_wr_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              stop_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [LANES-1:0]  dqm_i,
  output logic [COL_W-1:0]  col_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              beat_vld_o,
  output logic              beat_wr_o,
  output logic [LANES-1:0]  wr_en_o,
  output logic              rd_vld_o,
  output logic [LANES-1:0]  rd_oe_o
);
  logic             act, wr, ilv, cl3;
  logic [COL_W-1:0] start, cnt, mask;

  seq_burst_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctrl (
    .clk_i, .rst_ni, .cmd_vld_i, .cmd_wr_i, .col_i, .bank_i, .stop_i, .mode_i,
    .act_o(act), .wr_o(wr), .start_o(start), .cnt_o(cnt), .mask_o(mask),
    .ilv_o(ilv), .cl3_o(cl3), .bank_o(bank_o)
  );

  seq_col_gen #(.COL_W(COL_W)) u_col (
    .start_i(start), .cnt_i(cnt), .mask_i(mask), .ilv_i(ilv), .col_o(col_o)
  );

  seq_read_pipe #(.LANES(LANES)) u_rd (
    .clk_i, .rst_ni, .rd_beat_i(act & ~wr), .cl3_i(cl3), .dqm_i,
    .rd_vld_o, .rd_oe_o
  );

  assign beat_vld_o = act;
  assign beat_wr_o  = act & wr;

  // write mask acts in the same cycle
  for (genvar g = 0; g < LANES; g++) begin : g_wlane
    assign wr_en_o[g] = act & wr & ~dqm_i[g];
  end
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int LANES  = 2,
  parameter int MODE_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_vld_i,
  input logic              cmd_wr_i,
  input logic [COL_W-1:0]  col_i,
  input logic [BANK_W-1:0] bank_i,
  input logic              stop_i,
  input logic [MODE_W-1:0] mode_i,
  input logic [LANES-1:0]  dqm_i,
  input logic [COL_W-1:0]  col_o,
  input logic [BANK_W-1:0] bank_o,
  input logic              beat_vld_o,
  input logic              beat_wr_o,
  input logic [LANES-1:0]  wr_en_o,
  input logic              rd_vld_o,
  input logic [LANES-1:0]  rd_oe_o
);
  assert_first_beat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_i |=> beat_vld_o && col_o == $past(col_i));

  assert_bank_latch_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_i |=> bank_o == $past(bank_i));

  assert_stop_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !cmd_vld_i |=> !beat_vld_o);

  assert_wr_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o != '0) |-> beat_wr_o && ((wr_en_o & dqm_i) == '0));

  assert_rd_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> $past(beat_vld_o && !beat_wr_o) || $past(beat_vld_o && !beat_wr_o, 2));

  assert_rd_mask_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_oe_o != '0) |-> rd_vld_o && ((rd_oe_o & $past(dqm_i, 2)) == '0));
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(
  .COL_W(COL_W), .BANK_W(BANK_W), .LANES(LANES), .MODE_W(sdram_seq_pkg::MODE_W)
) u_chk (.*);

// File: tb/sim_sdram_burst_seq.sv
module sim_sdram_burst_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_vld = 1'b0, cmd_wr = 1'b0, stop = 1'b0;
  logic [8:0] col = '0;
  logic [1:0] bank = '0;
  logic [9:0] mode = '0;
  logic [1:0] dqm = '0;

  logic [8:0] col_o;
  logic [1:0] bank_o, wr_en_o, rd_oe_o;
  logic       beat_vld_o, beat_wr_o, rd_vld_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_vld_i(cmd_vld), .cmd_wr_i(cmd_wr),
    .col_i(col), .bank_i(bank), .stop_i(stop), .mode_i(mode), .dqm_i(dqm),
    .col_o(col_o), .bank_o(bank_o), .beat_vld_o(beat_vld_o), .beat_wr_o(beat_wr_o),
    .wr_en_o(wr_en_o), .rd_vld_o(rd_vld_o), .rd_oe_o(rd_oe_o)
  );

  int    checks = 0, errors = 0;
  string tag = "R1";

  // reference model state
  int         cyc = 0;
  bit         m_act = 0, m_wr = 0, m_ilv = 0;
  int         m_start = 0, m_idx = 0, m_len = 1, m_cl = 2, m_bank = 0;
  bit         rdexp[int];
  logic [1:0] dqm_hist[int];

  function automatic int len_of(logic [9:0] m, bit wr);
    if (wr && m[9]) return 1;
    case (m[2:0])
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 512;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    dqm_hist[cyc] = dqm;
    if (!rst_n) begin
      m_act = 0; m_bank = 0;
    end else if (cmd_vld) begin
      m_act = 1; m_wr = cmd_wr; m_start = col; m_idx = 0; m_bank = bank;
      m_len = len_of(mode, cmd_wr); m_ilv = mode[3];
      m_cl = (mode[6:4] == 3'b011) ? 3 : 2;
    end else if (stop) begin
      m_act = 0;
    end else if (m_act) begin
      m_idx++;
      if (m_len != 512 && m_idx == m_len) m_act = 0;
    end
    if (rst_n && m_act && !m_wr) rdexp[cyc + m_cl - 1] = 1;
  end

  function automatic int exp_col();
    int base, off;
    if (m_len == 512) return (m_start + m_idx) % 512;
    base = m_start - (m_start % m_len);
    off  = m_start % m_len;
    if (m_ilv) return base + (off ^ m_idx);
    return base + ((off + m_idx) % m_len);
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d got %0d exp %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic tick();
    int ev, eoe;
    @(negedge clk);
    ev  = rdexp.exists(cyc) ? 1 : 0;
    eoe = 0;
    if (ev && dqm_hist.exists(cyc - 1)) eoe = int'(~dqm_hist[cyc - 1] & 2'b11);
    else if (ev) eoe = 3;
    chk("beat_vld", int'(beat_vld_o), int'(m_act));
    chk("beat_wr", int'(beat_wr_o), int'(m_act && m_wr));
    if (m_act) chk("col", int'(col_o), exp_col());
    chk("bank", int'(bank_o), m_bank);
    chk("wr_en", int'(wr_en_o), (m_act && m_wr) ? int'(~dqm & 2'b11) : 0);
    chk("rd_vld", int'(rd_vld_o), ev);
    chk("rd_oe", int'(rd_oe_o), eoe);
  endtask

  function automatic logic [9:0] mk(logic [2:0] bl, bit ilv, int cl, bit wbs);
    logic [9:0] m = '0;
    m[2:0] = bl; m[3] = ilv; m[6:4] = (cl == 3) ? 3'b011 : 3'b010; m[9] = wbs;
    return m;
  endfunction

  task automatic issue(bit wr, int c, int b, logic [9:0] m);
    cmd_vld = 1; cmd_wr = wr; col = 9'(c); bank = 2'(b); mode = m;
    tick();
    cmd_vld = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    tag = "R1"; run(3); rst_n = 1; run(2);

    tag = "R3"; issue(0, 13, 1, mk(3'b010, 0, 2, 0)); run(6);
    issue(0, 6, 0, mk(3'b011, 0, 2, 0)); run(10);
    issue(0, 20, 0, mk(3'b101, 0, 2, 0)); run(3);

    tag = "R4"; issue(0, 5, 2, mk(3'b011, 1, 2, 0)); run(10);
    issue(0, 502, 3, mk(3'b010, 1, 2, 0)); run(6);
    issue(0, 3, 0, mk(3'b111, 1, 2, 0)); run(6); stop = 1; tick(); stop = 0;

    tag = "R5"; issue(0, 100, 0, mk(3'b000, 0, 2, 0)); run(4);
    issue(1, 7, 1, mk(3'b001, 0, 2, 0)); run(4);

    tag = "R6"; issue(0, 508, 2, mk(3'b111, 0, 2, 0)); run(520);
    tag = "R7"; stop = 1; tick(); stop = 0; run(5);
    issue(0, 30, 1, mk(3'b011, 0, 2, 0)); run(2);
    stop = 1; cmd_vld = 1; cmd_wr = 1; col = 9'd64; mode = mk(3'b001, 0, 2, 0);
    tick(); stop = 0; cmd_vld = 0; run(4);

    tag = "R8"; issue(0, 16, 0, mk(3'b011, 0, 2, 0)); run(3);
    tag = "R13"; issue(1, 40, 2, mk(3'b010, 0, 2, 0)); run(6);

    tag = "R9"; issue(1, 9, 1, mk(3'b011, 0, 2, 1)); run(4);
    issue(0, 9, 1, mk(3'b010, 0, 2, 1)); run(6);

    tag = "R10"; issue(1, 0, 3, mk(3'b011, 0, 2, 0));
    for (int i = 0; i < 10; i++) begin dqm = 2'(i); tick(); end
    dqm = 0;

    tag = "R11"; issue(0, 33, 0, mk(3'b010, 0, 3, 0)); run(8);
    issue(0, 40, 0, mk(3'b001, 0, 2, 0)); run(5);

    tag = "R12"; issue(0, 48, 1, mk(3'b011, 0, 2, 0));
    for (int i = 0; i < 12; i++) begin dqm = 2'(i * 3); tick(); end
    issue(0, 56, 1, mk(3'b011, 0, 3, 0));
    for (int i = 0; i < 12; i++) begin dqm = 2'(i + 1); tick(); end
    dqm = 0; run(3);

    tag = "R2"; issue(0, 1, 0, mk(3'b010, 0, 2, 0));
    issue(1, 2, 1, mk(3'b010, 0, 2, 0));
    issue(0, 3, 2, mk(3'b010, 1, 3, 0)); run(8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule